// File: doc/BRIEF.md
# Indirect-Indexed Codec Control Register File

This block is the control register file of an audio codec, placed on a simple 32-bit bus that carries byte addresses. It decodes a 64-byte window as sixteen 32-bit direct registers. Direct register 0 holds a pointer. Its low five bits select one of thirty-two 8-bit indirect registers. Direct register 1 is the data port into that indirect bank. Software sets the pointer, then reads or writes the data port.

Some indirect entries have their own access rules. One entry cannot be read back. Two entries ignore writes. One entry keeps a fixed codec code and accepts a single writable bit. Direct register 2 ignores writes. Direct register 4 is a control register, and bit 0 of a write to it starts a soft reset. Both resets leave the same state, including two identification codes in the indirect bank. The bus carries no streaming data: one access per cycle, qualified by a select and a write flag. Read data is registered. The interrupt pin is present but is always held low.

Top module: `codec_ctl_regs`

## Requirements
- R1: After a hardware reset, every direct register reads 0. Every indirect register reads 0, except index 12, which reads 0x8A, and index 25, which reads 0xA0.
- R2: The register number is `bus_addr[5:2]`, and `bus_addr[1:0]` are ignored. Direct registers 0, 3 and 5 to 15 store and return all 32 bits written.
- R3: The indirect index is bits [4:0] of direct register 0, and its upper bits take no part in selection. A write to direct register 1 stores `bus_wdata[7:0]` into the indexed entry. A read of direct register 1 returns the indexed entry zero-extended to 32 bits.
- R4: A read through the data port while the index is 3 returns 0, whatever was written there.
- R5: Writes through the data port to indices 11 and 25 leave those entries unchanged.
- R6: A write through the data port to index 12 leaves the entry equal to `(bus_wdata & 0x40) | 0x8A`.
- R7: Writes to direct register 2 are ignored, and it always reads 0.
- R8: A write to direct register 4 stores `bus_wdata[6:0]` zero-extended. If `bus_wdata[0]` is 1, every other direct and indirect register returns to its R1 value in the same cycle. Direct register 4 still holds the new masked value.
- R9: A read access (`bus_sel`=1, `bus_wr`=0) presents its data on `bus_rdata` with `bus_rvalid`=1 in the following cycle. A cycle after any other access, or after no access, has `bus_rvalid`=0.
- R10: `irq` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read (valid with bus_sel) |
| bus_addr | input | 6 | Byte address inside the 64-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq | output | 1 | Interrupt request, held low |

## Verification
The bench sweeps every direct register and every indirect index. It writes patterns that put stray upper bits in the pointer register, so a design that decodes the index from too many bits reads the wrong entry. It also writes full bytes with the upper data bits set, so a design that does not zero-extend data-port reads returns non-zero upper bits. It reads the write-only entry after writing it: a design without the masking returns the stored byte. It writes both read-only entries: a design that lets those writes through loses the identification code. It drives the version entry with all ones and with all zeros, which catches a design that drops bit 6 or the fixed code. Control writes are tried with bit 0 clear and with bit 0 set. A design that resets on any control write, skips the indirect bank, reloads no codes, or lets the soft reset wipe the new control value fails the full read-back that follows.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

  // Direct register numbers with special behaviour
  localparam int unsigned DR_POINTER = 0;
  localparam int unsigned DR_WINDOW  = 1;
  localparam int unsigned DR_LOCKED  = 2;
  localparam int unsigned DR_CONTROL = 4;
  localparam int unsigned CONTROL_KEEP_W = 7;

  // Indirect indices with special behaviour
  localparam int unsigned IX_HIDDEN   = 3;
  localparam int unsigned IX_FROZEN   = 11;
  localparam int unsigned IX_CODEC_ID = 12;
  localparam int unsigned IX_CHIP_ID  = 25;

  localparam logic [7:0] CODEC_ID_CODE = 8'h8A;
  localparam logic [7:0] CHIP_ID_CODE  = 8'hA0;
  localparam logic [7:0] CODEC_ID_WMASK = 8'h40;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  function automatic logic [7:0] ind_reset_value(input int unsigned ix);
    if (ix == IX_CODEC_ID) return CODEC_ID_CODE;
    if (ix == IX_CHIP_ID)  return CHIP_ID_CODE;
    return 8'h00;
  endfunction

endpackage

// File: rtl/ccr_direct_bank.sv
module ccr_direct_bank
  import codec_ctl_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_DIRECT = 16,
  parameter int unsigned IDX_W    = 5,
  localparam int unsigned SEL_W   = $clog2(N_DIRECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              soft_clr,
  output logic [IDX_W-1:0]  ind_idx,
  output logic [DATA_W-1:0] dir_q [N_DIRECT]
);

  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << CONTROL_KEEP_W) - 1);

  assign soft_clr = wr_en && (wr_sel == SEL_W'(DR_CONTROL)) && wr_data[0];
  assign ind_idx  = dir_q[DR_POINTER][IDX_W-1:0];

  for (genvar i = 0; i < N_DIRECT; i++) begin : g_reg
    if (i == DR_WINDOW || i == DR_LOCKED) begin : g_none
      // no storage: the data port reads the indirect bank, the locked reg reads zero
      assign dir_q[i] = '0;
    end else if (i == DR_CONTROL) begin : g_ctrl
      // the masked write value wins over the clear it triggers
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          dir_q[i] <= '0;
        else if (wr_en && wr_sel == SEL_W'(i))
          dir_q[i] <= wr_data & CTRL_MASK;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          dir_q[i] <= '0;
        else if (soft_clr)
          dir_q[i] <= '0;
        else if (wr_en && wr_sel == SEL_W'(i))
          dir_q[i] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/ccr_indirect_bank.sv
module ccr_indirect_bank
  import codec_ctl_pkg::*;
#(
  parameter int unsigned IND_W = 8,
  parameter int unsigned N_IND = 32,
  localparam int unsigned IDX_W = $clog2(N_IND)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [IND_W-1:0] wr_data,
  output logic [IND_W-1:0] ind_q [N_IND]
);

  for (genvar i = 0; i < N_IND; i++) begin : g_ent
    localparam logic [IND_W-1:0] RST_V = IND_W'(ind_reset_value(i));
    if (i == IX_FROZEN || i == IX_CHIP_ID) begin : g_ro
      // read-only entries never change from their reset value
      assign ind_q[i] = RST_V;
    end else if (i == IX_CODEC_ID) begin : g_id
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ind_q[i] <= RST_V;
        else if (soft_clr)
          ind_q[i] <= RST_V;
        else if (wr_en && idx == IDX_W'(i))
          ind_q[i] <= (wr_data & IND_W'(CODEC_ID_WMASK)) | IND_W'(CODEC_ID_CODE);
      end
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ind_q[i] <= RST_V;
        else if (soft_clr)
          ind_q[i] <= RST_V;
        else if (wr_en && idx == IDX_W'(i))
          ind_q[i] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/ccr_read_path.sv
module ccr_read_path
  import codec_ctl_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_DIRECT = 16,
  parameter int unsigned IND_W    = 8,
  parameter int unsigned N_IND    = 32,
  localparam int unsigned SEL_W   = $clog2(N_DIRECT),
  localparam int unsigned IDX_W   = $clog2(N_IND)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] dir_q [N_DIRECT],
  input  logic [IND_W-1:0]  ind_q [N_IND],
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    if (rd_sel == SEL_W'(DR_WINDOW)) begin
      if (idx == IDX_W'(IX_HIDDEN))
        rd_mux = '0;
      else
        rd_mux = DATA_W'(ind_q[idx]);
    end else begin
      rd_mux = dir_q[rd_sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en)
        rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
  import codec_ctl_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_DIRECT = 16,
  parameter int unsigned IND_W    = 8,
  parameter int unsigned N_IND    = 32,
  localparam int unsigned SEL_W   = $clog2(N_DIRECT),
  localparam int unsigned IDX_W   = $clog2(N_IND),
  localparam int unsigned ADDR_W  = SEL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);

  acc_e              acc;
  logic [SEL_W-1:0]  reg_sel;
  logic              soft_clr;
  logic [IDX_W-1:0]  ind_idx;
  logic [DATA_W-1:0] dir_q [N_DIRECT];
  logic [IND_W-1:0]  ind_q [N_IND];
  logic              unused_addr_lo;

  assign unused_addr_lo = ^bus_addr[1:0];
  assign reg_sel = bus_addr[ADDR_W-1:2];
  assign acc = !bus_sel ? ACC_IDLE : (bus_wr ? ACC_WRITE : ACC_READ);
  assign irq = 1'b0;

  ccr_direct_bank #(
    .DATA_W(DATA_W), .N_DIRECT(N_DIRECT), .IDX_W(IDX_W)
  ) u_dir (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc == ACC_WRITE), .wr_sel(reg_sel), .wr_data(bus_wdata),
    .soft_clr(soft_clr), .ind_idx(ind_idx), .dir_q(dir_q)
  );

  ccr_indirect_bank #(
    .IND_W(IND_W), .N_IND(N_IND)
  ) u_ind (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .wr_en(acc == ACC_WRITE && reg_sel == SEL_W'(DR_WINDOW)),
    .idx(ind_idx), .wr_data(bus_wdata[IND_W-1:0]), .ind_q(ind_q)
  );

  ccr_read_path #(
    .DATA_W(DATA_W), .N_DIRECT(N_DIRECT), .IND_W(IND_W), .N_IND(N_IND)
  ) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_en(acc == ACC_READ), .rd_sel(reg_sel), .idx(ind_idx),
    .dir_q(dir_q), .ind_q(ind_q),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

endmodule

// File: rtl/codec_ctl_regs_chk.sv
module codec_ctl_regs_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              irq,
  input logic [IDX_W-1:0]  ind_idx
);

  logic rd_req, wr_req;
  logic [ADDR_W-3:0] rnum;
  assign rd_req = bus_sel && !bus_wr;
  assign wr_req = bus_sel && bus_wr;
  assign rnum   = bus_addr[ADDR_W-1:2];

  // R10
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !irq);

  // R9
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  // R9
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);

  // R7
  locked_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rnum == 2) |=> (bus_rdata == '0));

  // R4
  hidden_entry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rnum == 1 && ind_idx == 3) |=> (bus_rdata == '0));

  // R6
  codec_id_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rnum == 1 && ind_idx == 12) |=> ((bus_rdata & ~DATA_W'(32'h40)) == DATA_W'(32'h8A)));

  // R5
  chip_id_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rnum == 1 && ind_idx == 25) |=> (bus_rdata == DATA_W'(32'hA0)));

  // R8
  soft_reset_pointer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && rnum == 4 && bus_wdata[0]) |=> (ind_idx == '0));

endmodule

bind codec_ctl_regs codec_ctl_regs_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .irq(irq), .ind_idx(ind_idx)
);

// File: tb/sim_codec_ctl_regs.sv
module sim_codec_ctl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_dir [16];
  logic [7:0]  m_ind [32];

  always #2 clk = ~clk;

  codec_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R1 values, also the soft reset target of R8
  task automatic model_defaults();
    for (int i = 0; i < 16; i++) m_dir[i] = 32'h0;
    for (int i = 0; i < 32; i++) m_ind[i] = (i == 12) ? 8'h8A : (i == 25) ? 8'hA0 : 8'h00;
  endtask

  task automatic model_write(input int r, input logic [31:0] d);
    int ix;
    ix = int'(m_dir[0][4:0]);
    case (r)
      1: begin
        if (ix == 12) m_ind[ix] = (d[7:0] & 8'h40) | 8'h8A;
        else if (ix != 11 && ix != 25) m_ind[ix] = d[7:0];
      end
      2: ;
      4: begin
        if (d[0]) model_defaults();
        m_dir[4] = d & 32'h7F;
      end
      default: m_dir[r] = d;
    endcase
  endtask

  function automatic logic [31:0] model_read(input int r);
    int ix;
    ix = int'(m_dir[0][4:0]);
    if (r == 1) return (ix == 3) ? 32'h0 : {24'h0, m_ind[ix]};
    return m_dir[r];
  endfunction

  task automatic wr(input int r, input logic [31:0] d, input logic [1:0] lo);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {4'(r), lo}; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    model_write(r, d);
    check(bus_rvalid == 1'b0, "R9 no rvalid after write", 32'(bus_rvalid), 32'h0);
  endtask

  task automatic rd(input int r, input string tag);
    logic [31:0] e;
    e = model_read(r);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {4'(r), 2'b00};
    @(negedge clk);
    bus_sel = 1'b0;
    check(bus_rvalid == 1'b1, "R9 rvalid after read", 32'(bus_rvalid), 32'h1);
    check(bus_rdata == e, tag, bus_rdata, e);
    check(irq == 1'b0, "R10 irq low", 32'(irq), 32'h0);
  endtask

  task automatic sweep_all(input string tag);
    logic [31:0] saved;
    for (int r = 0; r < 16; r++) rd(r, {tag, " direct R2"});
    saved = m_dir[0];
    for (int i = 0; i < 32; i++) begin
      wr(0, {saved[31:5], 5'(i)}, 2'b00);
      rd(1, {tag, " indirect R3"});
    end
    wr(0, saved, 2'b00);
  endtask

  initial begin
    model_defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_rvalid == 1'b0, "R9 idle after reset", 32'(bus_rvalid), 32'h0);
    check(irq == 1'b0, "R10 irq at reset", 32'(irq), 32'h0);

    // R1 reset state across both banks
    sweep_all("R1 reset");

    // R2 / R7: full-width patterns into every direct register but the window and control
    for (int r = 0; r < 16; r++)
      if (r != 1 && r != 4) wr(r, 32'hA5C3_0000 ^ (32'(r) * 32'h0101_1011), 2'(r));
    for (int r = 0; r < 16; r++) rd(r, "R2 R7 direct readback");

    // R3 R4 R5 R6: write every index with upper junk in the pointer and data
    for (int i = 0; i < 32; i++) begin
      wr(0, {27'(i * 32'h0123_4567 + 1), 5'(i)}, 2'b00);
      wr(1, 32'hFFFF_FF00 | 32'((i * 37 + 11) & 8'hFF), 2'b11);
    end
    sweep_all("R3 R4 R5 R6 after writes");

    // R6 with the writable bit both ways
    wr(0, 32'd12, 2'b00);
    wr(1, 32'hFFFF_FFFF, 2'b00); rd(1, "R6 all ones");
    wr(1, 32'h0000_0000, 2'b00); rd(1, "R6 all zeros");
    wr(1, 32'h0000_0040, 2'b00); rd(1, "R6 bit6 only");

    // R5: try to overwrite both read-only entries
    wr(0, 32'd25, 2'b00); wr(1, 32'h0000_0055, 2'b00); rd(1, "R5 idx25");
    wr(0, 32'd11, 2'b00); wr(1, 32'h0000_00FF, 2'b00); rd(1, "R5 idx11");

    // R4: written but unreadable
    wr(0, 32'd3, 2'b00); wr(1, 32'h0000_00C7, 2'b00); rd(1, "R4 hidden");

    // R8: control write without bit 0 changes nothing else
    wr(0, 32'hDEAD_BE07, 2'b00);
    wr(4, 32'hFFFF_FFFE, 2'b00);
    sweep_all("R8 no soft reset");

    // R8: control write with bit 0 resets everything else
    wr(4, 32'hFFFF_FFFF, 2'b01);
    for (int r = 0; r < 16; r++) rd(r, "R8 soft reset direct");
    check(m_dir[4] == 32'h7F, "R8 model control value", m_dir[4], 32'h7F);
    sweep_all("R8 soft reset");

    // R8: second soft reset with a different masked value
    wr(5, 32'h1234_5678, 2'b00);
    wr(4, 32'h0000_0081, 2'b00);
    rd(4, "R8 masked 0x81"); rd(5, "R8 cleared reg5");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule